// File: doc/BRIEF.md
# Split-Byte Converter Capture Controller

This block sits between a sample-and-hold stage, a 12-bit analog-to-digital converter and a downstream processing stage. The converter's result is reached through an 8-bit data bus, so each sample is fetched in two ordered bus transfers. The upper eight bits come first, then the lower four bits. The controller waits for the sample-and-hold stage to raise its data-ready flag. It then switches the converter from conversion mode to read mode and issues a read strobe for each transfer. After each strobe it lets the bus settle for a set number of cycles before it latches the bus.

When both halves are in, the controller joins them into one 12-bit word and presents that word with a one-cycle valid strobe. In the same cycle it pulses a clear request for the ready flag and puts the converter back into conversion mode. After reset it runs one initialisation step: it clears the flag and puts the converter into conversion mode. A sticky error bit records a ready flag that rises again while a capture is in progress.

The flag source must drop the flag before the clock edge that ends the clear pulse. Otherwise the controller starts a fresh capture.

Top module: `adc_split_capture`

## Requirements
- R1: While `rst_n` is low, `flag_clear` is 1, `conv_mode` is 1 and `rd_strobe`, `sample_valid` and `overrun` are 0. After the first rising edge with `rst_n` high, `flag_clear` returns to 0.
- R2: A capture starts only when `data_avail` is 1 while the controller is idle. `conv_mode` falls to 0 (read mode) one full cycle before the first read strobe.
- R3: `rd_strobe` is asserted only while `conv_mode` is 0. Each strobe lasts one cycle, and each capture issues exactly two strobes.
- R4: After each strobe cycle, `bus_data` is latched at the clock edge that ends the SETTLE_CYC-th cycle after that strobe cycle. Values on the bus at any other time are not used.
- R5: The first transfer supplies `sample_data[11:4]` from `bus_data[7:0]`. The second transfer supplies `sample_data[3:0]` from `bus_data[3:0]`. `bus_data[7:4]` is ignored during the second transfer.
- R6: After the second transfer, `sample_valid` is 1 for exactly one cycle. In that same cycle `flag_clear` is 1 and `conv_mode` is 1. `sample_data` holds its value until the next capture completes.
- R7: If `data_avail` rises while a capture is in progress (from the read-mode switch through the valid cycle), `overrun` becomes 1 and stays 1 until reset. A flag that stays high through the capture without a new rise does not set `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_avail | input | 1 | Ready flag from the sample-and-hold stage |
| bus_data | input | 8 | Byte bus from the converter |
| conv_mode | output | 1 | 1 = converter in conversion mode, 0 = read mode |
| rd_strobe | output | 1 | One-cycle read request for a bus transfer |
| flag_clear | output | 1 | Request to clear the ready flag |
| sample_data | output | 12 | Assembled sample |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |
| overrun | output | 1 | Sticky flag-rise-during-capture error |

## Verification
All 4096 sample codes are captured. On the second transfer the bus carries the inverse of the wanted nibble in its upper bits, so a swapped or mis-sliced half shows up as a wrong word. Outside the single settle cycle the converter model drives a rolling garbage byte, so latching one cycle early or late is caught on every capture. In a normal capture the flag stays high and must leave `overrun` clear. A capture in which the flag drops and rises again must set `overrun`, deliver the correct word anyway, and keep `overrun` set through a later clean capture.

// File: rtl/adc_cap_pkg.sv
// Shared types for the split-byte capture controller.
// Assumes: the state encoding stays private to the controller.
package adc_cap_pkg;

    typedef enum logic [2:0] {
        S_INIT   = 3'd0,
        S_IDLE   = 3'd1,
        S_ARM    = 3'd2,
        S_STRB_H = 3'd3,
        S_WAIT_H = 3'd4,
        S_STRB_L = 3'd5,
        S_WAIT_L = 3'd6,
        S_DONE   = 3'd7
    } cap_state_t;

endpackage

// File: rtl/adc_settle_timer.sv
// Counts the settle window that follows a read strobe.
// Assumes: SETTLE_CYC >= 1; start and run are never asserted together.
module adc_settle_timer #(
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // done marks the last cycle of the window
    assign done = run && (cnt == LAST);

    // counter: cleared on strobe, advances while waiting
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (start)        cnt <= '0;
        else if (run && !done) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_byte_merge.sv
// Joins the high byte and the low bits into one sample word.
// Assumes: cap_hi comes before cap_lo within a capture.
module adc_byte_merge #(
    parameter int BUS_W    = 8,
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_hi,
    input  logic                cap_lo,
    input  logic [BUS_W-1:0]    hi_in,
    input  logic [SAMPLE_W-BUS_W-1:0] lo_in,
    output logic [SAMPLE_W-1:0] word
);
    logic [BUS_W-1:0] hi_q;

    // hold the first transfer until the second arrives
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (cap_hi) hi_q <= hi_in;
    end

    // assemble the word on the second transfer
    always_ff @(posedge clk) begin
        if (!rst_n)      word <= '0;
        else if (cap_lo) word <= {hi_q, lo_in};
    end
endmodule

// File: rtl/adc_overrun_flag.sv
// Sticky error set by a rising ready flag during a capture.
// Assumes: busy covers the read-mode switch through the valid cycle.
module adc_overrun_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic data_avail,
    output logic overrun
);
    logic avail_q;

    // previous flag level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) avail_q <= 1'b0;
        else        avail_q <= data_avail;
    end

    // sticky latch, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)                                overrun <= 1'b0;
        else if (busy && data_avail && !avail_q)   overrun <= 1'b1;
    end
endmodule

// File: rtl/adc_cap_fsm.sv
// Sequencer: init, wait for flag, read mode, two strobed transfers, done.
// Assumes: the flag source drops the flag before the edge that ends flag_clear.
module adc_cap_fsm
    import adc_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_avail,
    input  logic settle_done,
    output logic conv_mode,
    output logic rd_strobe,
    output logic flag_clear,
    output logic sample_valid,
    output logic cap_hi,
    output logic cap_lo,
    output logic tmr_start,
    output logic tmr_run,
    output logic busy
);
    cap_state_t st, nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_INIT;
        else        st <= nx;
    end

    // next-state selection
    always_comb begin
        nx = st;
        unique case (st)
            S_INIT:   nx = S_IDLE;
            S_IDLE:   if (data_avail) nx = S_ARM;
            S_ARM:    nx = S_STRB_H;
            S_STRB_H: nx = S_WAIT_H;
            S_WAIT_H: if (settle_done) nx = S_STRB_L;
            S_STRB_L: nx = S_WAIT_L;
            S_WAIT_L: if (settle_done) nx = S_DONE;
            S_DONE:   nx = S_IDLE;
            default:  nx = S_INIT;
        endcase
    end

    // output decode from the current state
    always_comb begin
        conv_mode    = (st == S_INIT) || (st == S_IDLE) || (st == S_DONE);
        rd_strobe    = (st == S_STRB_H) || (st == S_STRB_L);
        flag_clear   = (st == S_INIT) || (st == S_DONE);
        sample_valid = (st == S_DONE);
        tmr_start    = rd_strobe;
        tmr_run      = (st == S_WAIT_H) || (st == S_WAIT_L);
        cap_hi       = (st == S_WAIT_H) && settle_done;
        cap_lo       = (st == S_WAIT_L) && settle_done;
        busy         = (st != S_INIT) && (st != S_IDLE);
    end
endmodule

// File: rtl/adc_split_capture.sv
// Top: captures a wide converter result over a narrow bus in two reads.
// Assumes: BUS_W < SAMPLE_W <= 2*BUS_W; SETTLE_CYC >= 1.
module adc_split_capture #(
    parameter int BUS_W      = 8,
    parameter int SAMPLE_W   = 12,
    parameter int SETTLE_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                data_avail,
    input  logic [BUS_W-1:0]    bus_data,
    output logic                conv_mode,
    output logic                rd_strobe,
    output logic                flag_clear,
    output logic [SAMPLE_W-1:0] sample_data,
    output logic                sample_valid,
    output logic                overrun
);
    localparam int LO_W = SAMPLE_W - BUS_W;

    logic settle_done, cap_hi, cap_lo, tmr_start, tmr_run, busy;

    adc_cap_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .data_avail(data_avail),
        .settle_done(settle_done), .conv_mode(conv_mode),
        .rd_strobe(rd_strobe), .flag_clear(flag_clear),
        .sample_valid(sample_valid), .cap_hi(cap_hi), .cap_lo(cap_lo),
        .tmr_start(tmr_start), .tmr_run(tmr_run), .busy(busy)
    );

    adc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .run(tmr_run),
        .done(settle_done)
    );

    adc_byte_merge #(.BUS_W(BUS_W), .SAMPLE_W(SAMPLE_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .cap_hi(cap_hi), .cap_lo(cap_lo),
        .hi_in(bus_data), .lo_in(bus_data[LO_W-1:0]), .word(sample_data)
    );

    adc_overrun_flag u_ovr (
        .clk(clk), .rst_n(rst_n), .busy(busy), .data_avail(data_avail),
        .overrun(overrun)
    );
endmodule

// File: rtl/adc_split_capture_chk.sv
// Protocol checker for the capture controller, bound to the top.
module adc_split_capture_chk (
    input logic clk,
    input logic rst_n,
    input logic data_avail,
    input logic conv_mode,
    input logic rd_strobe,
    input logic flag_clear,
    input logic sample_valid,
    input logic overrun
);
    // R2
    read_mode_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_mode) |-> $past(data_avail));
    // R3
    strobe_in_read_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> !conv_mode);
    // R3
    strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe);
    // R6
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);
    // R6
    valid_with_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (flag_clear && conv_mode));
    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind adc_split_capture adc_split_capture_chk u_chk (
    .clk(clk), .rst_n(rst_n), .data_avail(data_avail),
    .conv_mode(conv_mode), .rd_strobe(rd_strobe), .flag_clear(flag_clear),
    .sample_valid(sample_valid), .overrun(overrun)
);

// File: tb/tb_adc_split_capture.sv
module tb_adc_split_capture;
    localparam int SETTLE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        data_avail = 1'b0;
    logic [7:0]  bus_data = 8'h00;
    logic        conv_mode, rd_strobe, flag_clear, sample_valid, overrun;
    logic [11:0] sample_data;

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;

    adc_split_capture #(.BUS_W(8), .SAMPLE_W(12), .SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .data_avail(data_avail), .bus_data(bus_data),
        .conv_mode(conv_mode), .rd_strobe(rd_strobe), .flag_clear(flag_clear),
        .sample_data(sample_data), .sample_valid(sample_valid), .overrun(overrun)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One capture with a converter model on the bus.
    // bounce: flag drops and rises again mid-capture.
    task automatic capture(input logic [11:0] val, input bit bounce, output bit ok);
        int n = -1;
        int strobes = 0;
        bit prev_conv = 1'b1;
        bit got = 1'b0;
        bit mode_ok = 1'b1;
        ok = 1'b1;
        @(negedge clk);
        data_avail = 1'b1;
        for (int cyc = 0; cyc < 60 && !got; cyc++) begin
            @(negedge clk);
            if (rd_strobe) begin
                strobes++;
                n = 0;
                // R2 and R3: read mode set before the strobe and held during it
                if (conv_mode || (strobes == 1 && prev_conv)) mode_ok = 1'b0;
            end else if (n >= 0) begin
                n++;
            end
            prev_conv = conv_mode;
            if (n == SETTLE)
                bus_data = (strobes == 1) ? val[11:4] : {~val[3:0], val[3:0]};
            else
                bus_data = 8'hA5 ^ 8'(cyc * 37);
            if (bounce && cyc == 3) data_avail = 1'b0;
            if (bounce && cyc == 5) data_avail = 1'b1;
            if (sample_valid) begin
                got = 1'b1;
                // R5 and R4: assembled word
                if (sample_data !== val) begin
                    ok = 1'b0;
                    chk(1'b0, "R5/R4 sample", int'(sample_data), int'(val));
                end
                // R6: clear and conversion mode alongside valid
                if (!(flag_clear && conv_mode)) begin
                    ok = 1'b0;
                    chk(1'b0, "R6 clear/mode", int'({flag_clear, conv_mode}), 3);
                end
                // R3: two strobes
                if (strobes != 2) begin
                    ok = 1'b0;
                    chk(1'b0, "R3 strobes", strobes, 2);
                end
                data_avail = 1'b0;
            end
        end
        if (!got) begin
            ok = 1'b0;
            chk(1'b0, "R6 no valid", 0, 1);
        end
        if (!mode_ok) begin
            ok = 1'b0;
            chk(1'b0, "R2/R3 read mode", 0, 1);
        end
        @(negedge clk);
        // R6: valid lasts one cycle, word held
        if (sample_valid || sample_data !== val) begin
            ok = 1'b0;
            chk(1'b0, "R6 hold", int'(sample_data), int'(val));
        end
    endtask

    initial begin
        bit ok;
        int bad;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(flag_clear && conv_mode && !rd_strobe && !sample_valid && !overrun,
            "R1 reset", int'({flag_clear, conv_mode, rd_strobe, sample_valid, overrun}), 5'b11000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!flag_clear && conv_mode, "R1 init done", int'({flag_clear, conv_mode}), 1);
        // R2: nothing happens without the flag
        bad = 0;
        repeat (8) begin
            @(negedge clk);
            if (rd_strobe || !conv_mode || sample_valid) bad++;
        end
        chk(bad == 0, "R2 idle", bad, 0);

        // R4 R5: every code
        bad = 0;
        for (int v = 0; v < 4096; v++) begin
            capture(12'(v), 1'b0, ok);
            if (!ok) bad++;
        end
        chk(bad == 0, "R5 sweep", bad, 0);
        chk(bad == 0, "R4 settle sweep", bad, 0);
        // R7: steady flag never sets overrun
        chk(!overrun, "R7 steady flag", int'(overrun), 0);

        // R7: flag bounce during capture
        capture(12'hA5C, 1'b1, ok);
        chk(ok, "R7 bounce sample", int'(ok), 1);
        chk(overrun, "R7 overrun set", int'(overrun), 1);
        capture(12'h3F1, 1'b0, ok);
        chk(ok, "R5 after overrun", int'(ok), 1);
        chk(overrun, "R7 overrun sticky", int'(overrun), 1);
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule